// File: doc/BRIEF.md
# Precise Trap Controller for an In-Order Pipeline

This block decides, every cycle, whether the pipeline must abandon its normal flow because an instruction has faulted. Two stages can report a fault. Decode reports an undefined opcode. Execute reports an arithmetic overflow or a hardware malfunction. The block picks the fault that belongs to the oldest instruction. It then raises the flush lines for that instruction and every younger one, and steers the fetch address to the handler entry.

In the same cycle it loads two registers. The 64-bit return-link register receives the faulting PC plus 4. The 32-bit syndrome register receives the cause. The flush lines clear fetched-instruction and control fields the same way a taken-branch flush does, and the execute flush keeps the faulting instruction from writing its destination register.

The handler entry comes from one of two sources. In fixed mode it is a single constant address. In vectored mode it is a base register plus an offset chosen by the cause.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, link_o and syndrome_o are zero, and every flush output and redirect_o are low.
- R2: When no valid stage reports a fault, all flush outputs and redirect_o stay low and link_o and syndrome_o keep their values. A fault flag on an invalid stage (valid low) is ignored.
- R3: A fault in a valid execute stage raises flush_fetch_o, flush_decode_o, flush_exec_o and redirect_o in the same cycle.
- R4: A fault in a valid decode stage with no execute fault raises flush_fetch_o, flush_decode_o and redirect_o, and keeps flush_exec_o low so that the older instruction in execute completes.
- R5: When decode and execute both fault in one cycle, the execute fault is taken. Its PC and cause are recorded.
- R6: When one execute instruction flags both malfunction and overflow, malfunction is the recorded cause.
- R7: With vec_mode_i low, redirect_pc_o is 0x0000_0000_1C09_0000 for every cause.
- R8: With vec_mode_i high, redirect_pc_o is vec_base_i plus a 6-bit zero-extended offset. The offset is 0x00 for an undefined opcode, 0x2C for overflow and 0x3F for malfunction.
- R9: On the clock edge that ends a cycle with redirect_o high, link_o takes the taken instruction's PC plus 4.
- R10: On that same edge, syndrome_o takes 1 for overflow and 0 for an undefined opcode or a malfunction. Bits 31:1 of syndrome_o are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_mode_i | input | 1 | 1 selects vectored entry, 0 selects the fixed entry |
| vec_base_i | input | 64 | Vector table base address |
| dec_valid_i | input | 1 | Decode stage holds a real instruction |
| dec_undef_i | input | 1 | Decode found an undefined opcode |
| dec_pc_i | input | 64 | PC of the decode instruction |
| exe_valid_i | input | 1 | Execute stage holds a real instruction |
| exe_ovf_i | input | 1 | Execute arithmetic overflow |
| exe_hwerr_i | input | 1 | Execute hardware malfunction |
| exe_pc_i | input | 64 | PC of the execute instruction |
| flush_fetch_o | output | 1 | Clear the fetched instruction field |
| flush_decode_o | output | 1 | Zero the control fields entering execute |
| flush_exec_o | output | 1 | Cancel the execute instruction, including its write-back |
| redirect_o | output | 1 | Load redirect_pc_o into the PC |
| redirect_pc_o | output | 64 | Handler entry address |
| link_o | output | 64 | Return-link register |
| syndrome_o | output | 32 | Syndrome register |

## Verification
The checks take for granted that the pipeline drops the valid bit of every stage it was told to flush. A cancelled instruction must therefore never raise a fault in the following cycle. The checks also assume that PCs are word-aligned, so PC plus 4 never wraps in normal use. The stimulus draws the valid bits and fault flags independently every cycle, and it sometimes sets fault flags on invalid stages. After any cycle with a redirect it clears both valid bits for one cycle, as a flushing pipeline would. PCs are drawn as word-aligned values.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    CAUSE_UNDEF = 2'd0,
    CAUSE_OVF   = 2'd1,
    CAUSE_HWERR = 2'd2
  } cause_e;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              dec_valid_i,
  input  logic              dec_undef_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic              exe_valid_i,
  input  logic              exe_ovf_i,
  input  logic              exe_hwerr_i,
  input  logic [ADDR_W-1:0] exe_pc_i,
  output logic              take_o,
  output logic              from_exe_o,
  output cause_e            cause_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic exe_fault, dec_fault;

  assign exe_fault = exe_valid_i & (exe_ovf_i | exe_hwerr_i);
  assign dec_fault = dec_valid_i & dec_undef_i;

  // execute holds the older instruction; malfunction outranks overflow
  always_comb begin
    take_o     = exe_fault | dec_fault;
    from_exe_o = exe_fault;
    cause_o    = CAUSE_UNDEF;
    pc_o       = dec_pc_i;
    if (exe_fault) begin
      pc_o    = exe_pc_i;
      cause_o = exe_hwerr_i ? CAUSE_HWERR : CAUSE_OVF;
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 64,
  parameter int unsigned      OFS_W      = 6,
  parameter bit               VEC_EN     = 1'b1,
  parameter logic [ADDR_W-1:0] FIXED_ENTRY = 64'h0000_0000_1C09_0000,
  parameter logic [OFS_W-1:0] OFS_UNDEF  = 6'b000000,
  parameter logic [OFS_W-1:0] OFS_OVF    = 6'b101100,
  parameter logic [OFS_W-1:0] OFS_HWERR  = 6'b111111
) (
  input  logic              vec_mode_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  input  cause_e            cause_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned PAD_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] ofs;

  always_comb begin
    unique case (cause_i)
      CAUSE_OVF:   ofs = OFS_OVF;
      CAUSE_HWERR: ofs = OFS_HWERR;
      default:     ofs = OFS_UNDEF;
    endcase
  end

  generate
    if (VEC_EN) begin : g_vec
      assign target_o = vec_mode_i ? (vec_base_i + {{PAD_W{1'b0}}, ofs})
                                   : FIXED_ENTRY;
    end else begin : g_fixed
      logic unused;
      assign unused   = vec_mode_i ^ (^vec_base_i) ^ (^ofs);
      assign target_o = FIXED_ENTRY;
    end
  endgenerate
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SYN_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  cause_e            cause_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] link_o,
  output logic [SYN_W-1:0]  syndrome_o
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] link_q;
  logic              syn_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q    <= '0;
      syn_bit_q <= 1'b0;
    end else if (we_i) begin
      link_q    <= pc_i + INSN_BYTES;
      syn_bit_q <= (cause_i == CAUSE_OVF);
    end
  end

  assign link_o     = link_q;
  assign syndrome_o = {{(SYN_W-1){1'b0}}, syn_bit_q};
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 64,
  parameter int unsigned       SYN_W       = 32,
  parameter int unsigned       OFS_W       = 6,
  parameter bit                VEC_EN      = 1'b1,
  parameter logic [ADDR_W-1:0] FIXED_ENTRY = 64'h0000_0000_1C09_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vec_mode_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  input  logic              dec_valid_i,
  input  logic              dec_undef_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic              exe_valid_i,
  input  logic              exe_ovf_i,
  input  logic              exe_hwerr_i,
  input  logic [ADDR_W-1:0] exe_pc_i,
  output logic              flush_fetch_o,
  output logic              flush_decode_o,
  output logic              flush_exec_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic [ADDR_W-1:0] link_o,
  output logic [SYN_W-1:0]  syndrome_o
);
  logic              take, from_exe;
  cause_e            cause;
  logic [ADDR_W-1:0] fault_pc;

  trap_select #(.ADDR_W(ADDR_W)) u_sel (
    .dec_valid_i (dec_valid_i),
    .dec_undef_i (dec_undef_i),
    .dec_pc_i    (dec_pc_i),
    .exe_valid_i (exe_valid_i),
    .exe_ovf_i   (exe_ovf_i),
    .exe_hwerr_i (exe_hwerr_i),
    .exe_pc_i    (exe_pc_i),
    .take_o      (take),
    .from_exe_o  (from_exe),
    .cause_o     (cause),
    .pc_o        (fault_pc)
  );

  trap_vector #(
    .ADDR_W      (ADDR_W),
    .OFS_W       (OFS_W),
    .VEC_EN      (VEC_EN),
    .FIXED_ENTRY (FIXED_ENTRY)
  ) u_vec (
    .vec_mode_i (vec_mode_i),
    .vec_base_i (vec_base_i),
    .cause_i    (cause),
    .target_o   (redirect_pc_o)
  );

  trap_regs #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (take),
    .cause_i    (cause),
    .pc_i       (fault_pc),
    .link_o     (link_o),
    .syndrome_o (syndrome_o)
  );

  // younger stages are always cleared; execute only when it faulted
  assign flush_fetch_o  = take;
  assign flush_decode_o = take;
  assign flush_exec_o   = take & from_exe;
  assign redirect_o     = take;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int unsigned       ADDR_W      = 64,
  parameter int unsigned       SYN_W       = 32,
  parameter logic [ADDR_W-1:0] FIXED_ENTRY = 64'h0000_0000_1C09_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vec_mode_i,
  input logic              dec_valid_i,
  input logic              dec_undef_i,
  input logic [ADDR_W-1:0] dec_pc_i,
  input logic              exe_valid_i,
  input logic              exe_ovf_i,
  input logic              exe_hwerr_i,
  input logic [ADDR_W-1:0] exe_pc_i,
  input logic              flush_fetch_o,
  input logic              flush_decode_o,
  input logic              flush_exec_o,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] redirect_pc_o,
  input logic [ADDR_W-1:0] link_o,
  input logic [SYN_W-1:0]  syndrome_o
);
  logic exe_f, dec_f;
  assign exe_f = exe_valid_i & (exe_ovf_i | exe_hwerr_i);
  assign dec_f = dec_valid_i & dec_undef_i;

  // R2
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exe_f | dec_f) |=> $stable(link_o) && $stable(syndrome_o));

  // R3
  exe_flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_f |-> flush_fetch_o && flush_decode_o && flush_exec_o && redirect_o);

  // R4
  dec_keeps_exe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_f && !exe_f) |-> flush_fetch_o && flush_decode_o && !flush_exec_o);

  // R5
  exe_pc_linked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_f |=> link_o == $past(exe_pc_i) + 64'd4);

  // R7
  fixed_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !vec_mode_i) |-> redirect_pc_o == FIXED_ENTRY);

  // R9
  dec_pc_linked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_f && !exe_f) |=> link_o == $past(dec_pc_i) + 64'd4);

  // R10
  syn_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syndrome_o[SYN_W-1:1] == '0);
endmodule

bind trap_ctrl trap_ctrl_chk #(
  .ADDR_W(ADDR_W), .SYN_W(SYN_W), .FIXED_ENTRY(FIXED_ENTRY)
) u_chk (.*);

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_mode = 1'b0;
  logic [63:0] vec_base = '0;
  logic        dv = 1'b0, du = 1'b0, ev = 1'b0, eo = 1'b0, eh = 1'b0;
  logic [63:0] dpc = '0, epc = '0;
  logic        ff, fd, fe, rd;
  logic [63:0] rpc, link;
  logic [31:0] syn;

  int total = 0;
  int bad = 0;
  logic [63:0] m_link = '0;
  logic [31:0] m_syn = '0;
  bit flushed_prev = 0;

  always #5 clk = ~clk;

  trap_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .vec_mode_i(vec_mode), .vec_base_i(vec_base),
    .dec_valid_i(dv), .dec_undef_i(du), .dec_pc_i(dpc),
    .exe_valid_i(ev), .exe_ovf_i(eo), .exe_hwerr_i(eh), .exe_pc_i(epc),
    .flush_fetch_o(ff), .flush_decode_o(fd), .flush_exec_o(fe),
    .redirect_o(rd), .redirect_pc_o(rpc), .link_o(link), .syndrome_o(syn)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check registers, drive, check combinational outputs, update model
  task automatic step(bit v_mode, logic [63:0] base, bit d_v, bit d_u, logic [63:0] d_pc,
                      bit e_v, bit e_o, bit e_h, logic [63:0] e_pc);
    bit e_f, d_f, take;
    int cause; // 0 undef, 1 ovf, 2 hwerr
    logic [63:0] pc, tgt;
    @(negedge clk);
    chk("R9 link", link, m_link);
    chk("R10 syndrome", {32'd0, syn}, {32'd0, m_syn});
    vec_mode = v_mode; vec_base = base;
    dv = d_v; du = d_u; dpc = d_pc; ev = e_v; eo = e_o; eh = e_h; epc = e_pc;
    #1;
    e_f = e_v && (e_o || e_h);
    d_f = d_v && d_u;
    take = e_f || d_f;
    if (e_f) begin pc = e_pc; cause = e_h ? 2 : 1; end
    else begin pc = d_pc; cause = 0; end
    if (!v_mode) tgt = 64'h0000_0000_1C09_0000;
    else tgt = base + ((cause == 2) ? 64'h3F : (cause == 1) ? 64'h2C : 64'h0);
    chk(take ? "R3/R4 redirect" : "R2 redirect", {63'd0, rd}, {63'd0, take});
    chk(take ? "R3/R4 flush_fetch" : "R2 flush_fetch", {63'd0, ff}, {63'd0, take});
    chk(take ? "R3/R4 flush_decode" : "R2 flush_decode", {63'd0, fd}, {63'd0, take});
    chk(e_f ? "R3 flush_exec" : "R4 flush_exec", {63'd0, fe}, {63'd0, e_f});
    if (take) begin
      chk(v_mode ? "R8 target" : "R7 target", rpc, tgt);
      m_link = pc + 64'd4;
      m_syn  = (cause == 1) ? 32'd1 : 32'd0;
    end
    flushed_prev = take;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 link", link, 64'd0);
    chk("R1 syndrome", {32'd0, syn}, 64'd0);
    chk("R1 redirect", {60'd0, ff, fd, fe, rd}, 64'd0);
    rst_n = 1'b1;
    // R2 quiet, and fault flags on invalid stages
    step(0, 0, 1, 0, 64'h100, 1, 0, 0, 64'hFC);
    step(1, 64'h8000, 0, 1, 64'h200, 0, 1, 1, 64'h1FC);
    // R4 decode fault alone, fixed entry
    step(0, 0, 1, 1, 64'h40, 1, 0, 0, 64'h3C);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 execute overflow, R10 syndrome 1, R7
    step(0, 0, 1, 0, 64'h50, 1, 1, 0, 64'h4C);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 both fault, execute wins
    step(1, 64'h8000_0000, 1, 1, 64'h90, 1, 1, 0, 64'h8C);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 malfunction outranks overflow, R8 offset 0x3F
    step(1, 64'h8000_0100, 0, 0, 0, 1, 1, 1, 64'hA0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8 undef offset 0, then hwerr alone fixed
    step(1, 64'h1234_0000, 1, 1, 64'hB0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 1, 64'hC0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // random traffic respecting flush: stages invalid after a redirect
    for (int i = 0; i < 3000; i++) begin
      bit d_v, e_v;
      d_v = flushed_prev ? 1'b0 : 1'($urandom_range(0, 1));
      e_v = flushed_prev ? 1'b0 : 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 1)), {32'($urandom), 24'($urandom), 8'h00},
           d_v, ($urandom_range(0, 5) == 0), {32'($urandom), 30'($urandom), 2'b00},
           e_v, ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0),
           {32'($urandom), 30'($urandom), 2'b00});
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule